// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that behaves like a 512-byte serial EEPROM. It samples the bus clock and data lines on a fast system clock and drives the data line through an open-drain enable. When `sda_oe` is high the pad pulls SDA low, and when it is low the pad releases SDA. The block watches for start and stop conditions. It compares the 7-bit device address against a parameter and then handles one of two kinds of transaction. In a write, it takes two memory address bytes followed by any number of data bytes. In a read, it returns bytes from its internal pointer.

A write transaction loads the pointer from two address bytes, upper byte first. The block then stores each data byte at the pointer and advances the pointer. A random read starts the same way as a write. After the two address bytes the master issues a repeated start and then a read-addressed device byte, and data streams out from the loaded pointer. A read that is not preceded by address bytes continues from wherever the pointer was left. The storage is a register array that clears on reset.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, `sda_oe` is low and every one of the 512 bytes reads back as 0x00.
- R2: A high-to-low SDA transition while SCL is high (start) restarts reception of a device byte from any state, including in the middle of a byte.
- R3: A low-to-high SDA transition while SCL is high (stop) returns the block to idle with SDA released.
- R4: The first byte after a start carries the device address in bits 7..1 (MSB first) and the direction in bit 0 (0 = write, 1 = read). On a match the block pulls SDA low for the whole 9th clock. On a mismatch it leaves SDA released and ignores all bus activity until the next start.
- R5: Both memory address bytes are acknowledged. The upper byte comes first, and the pointer takes the low 9 bits of the 16-bit value, so address bits 15..9 have no effect.
- R6: Each write data byte is received MSB first, acknowledged, stored at the pointer, and then the pointer advances by one.
- R7: In a read, the byte at the pointer is driven MSB first, SDA is released on the 9th clock, and the pointer advances. A master ACK (SDA low on the 9th clock) starts the next byte. A master NACK stops all driving until the next start.
- R8: The pointer wraps from 511 to 0 on both reads and writes.
- R9: A repeated start after the two address bytes, followed by a read-addressed device byte, reads from the loaded pointer. A read without address bytes continues from the current pointer.
- R10: `sda_oe` only becomes asserted while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low, low releases it |

## Verification
The bound checker enforces several properties on every system clock. SDA is only pulled low during SCL-low phases. A start always leaves the block waiting for a device byte with its bit count cleared, and a stop always leaves it idle and released. A mismatched device byte never gets an acknowledge. Every stored byte advances the pointer by exactly one, with wrap at the top. The contents of the array can only be shown by the bench's transactions, which write and then read back through the bus. These cover random reads, reads that continue from the pointer, masked upper address bits, wrap at the end of the array, writes sent to a foreign address, a start in mid-byte and the quiet bus after a master NACK.

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int DEPTH = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [2:0] S_IDLE = 3'd0, S_DEV = 3'd1, S_AHI = 3'd2,
                         S_ALO = 3'd3, S_WDATA = 3'd4, S_RDATA = 3'd5;

  logic [1:0] scl_q, sda_q;
  logic scl_p, sda_p;
  logic [2:0] state;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txreg, ahi;
  logic [AW-1:0] ptr;
  logic mack;
  logic [7:0] mem [DEPTH];

  wire scl_s = scl_q[1];
  wire sda_s = sda_q[1];
  wire scl_rise  = scl_s & ~scl_p;
  wire scl_fall  = ~scl_s & scl_p;
  wire start_det = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  wire [AW-1:0] ptr_nxt = ptr + 1'b1;
  wire [7:0] rd_byte = mem[ptr];
  wire wr_en = (state == S_WDATA) && scl_fall && (bitcnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      txreg  <= '0;
      ahi    <= '0;
      ptr    <= '0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= S_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (state != S_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8 && state != S_RDATA) shreg <= {shreg[6:0], sda_s};
        if (bitcnt == 4'd8 && state == S_RDATA) mack <= ~sda_s;
        if (bitcnt < 4'd9) bitcnt <= bitcnt + 4'd1;
      end else if (scl_fall) begin
        if (state == S_RDATA) begin
          if (bitcnt < 4'd8) begin
            sda_oe <= ~txreg[6];
            txreg  <= {txreg[6:0], 1'b0};
          end else if (bitcnt == 4'd8) begin
            sda_oe <= 1'b0;
            ptr    <= ptr_nxt;
          end else if (mack) begin
            txreg  <= rd_byte;
            sda_oe <= ~rd_byte[7];
            bitcnt <= '0;
          end else begin
            state <= S_IDLE;
          end
        end else if (bitcnt == 4'd8) begin
          sda_oe <= 1'b1;
          case (state)
            S_DEV:   if (shreg[7:1] != DEV_ADDR) begin
                       sda_oe <= 1'b0;
                       state  <= S_IDLE;
                     end
            S_AHI:   ahi <= shreg;
            S_ALO:   ptr <= AW'({ahi, shreg});
            S_WDATA: ptr <= ptr_nxt;
            default: ;
          endcase
        end else if (bitcnt == 4'd9) begin
          sda_oe <= 1'b0;
          bitcnt <= '0;
          case (state)
            S_DEV:   if (shreg[0]) begin
                       state  <= S_RDATA;
                       txreg  <= rd_byte;
                       sda_oe <= ~rd_byte[7];
                     end else begin
                       state <= S_AHI;
                     end
            S_AHI:   state <= S_ALO;
            S_ALO:   state <= S_WDATA;
            default: ;
          endcase
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[ptr] <= shreg;
    end
endmodule

module i2c_eeprom_target_chk #(
  parameter int AW = 9,
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe,
  input logic [2:0] state,
  input logic [3:0] bitcnt,
  input logic [7:0] shreg,
  input logic [AW-1:0] ptr,
  input logic wr_en
);
  localparam logic [2:0] C_IDLE = 3'd0, C_DEV = 3'd1;

  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));
  // R2
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == C_DEV && bitcnt == 4'd0 && !sda_oe));
  // R2
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd9);
  // R3
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == C_IDLE && !sda_oe));
  // R4
  addr_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_DEV && scl_fall && bitcnt == 4'd8 && shreg[7:1] != DEV_ADDR)
      |=> (!sda_oe && state == C_IDLE));
  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr == AW'($past(ptr) + 1'b1));
  // R8
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (&ptr)) |=> ptr == '0);
endmodule

bind i2c_eeprom_target i2c_eeprom_target_chk #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .sda_oe(sda_oe),
  .state(state), .bitcnt(bitcnt), .shreg(shreg), .ptr(ptr), .wr_en(wr_en)
);

// File: tb/test_i2c_eeprom_target.sv
module test_i2c_eeprom_target;
  localparam int Q = 5;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire sda_line = sda_m & ~sda_oe;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] model [512];
  logic [7:0] wbuf [8];

  always #10 clk = ~clk;

  i2c_eeprom_target i_i2c_eeprom_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  function automatic int idx(input logic [15:0] a);
    return int'(a[8:0]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq();
    scl = 1'b1; wq(); wq();
    scl = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq();
    scl = 1'b1; wq();
    b = sda_line; wq();
    scl = 1'b0; wq();
  endtask

  task automatic send(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic recv(input bit ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(!ack);
  endtask

  task automatic wr_txn(input logic [15:0] a, input int n);
    bit ack;
    bus_start();
    send({DEV, 1'b0}, ack); chk(ack, "R4 device ack", ack, 1);
    send(a[15:8], ack);     chk(ack, "R5 upper ack", ack, 1);
    send(a[7:0], ack);      chk(ack, "R5 lower ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send(wbuf[i], ack);
      chk(ack, "R6 data ack", ack, 1);
      model[(idx(a) + i) % 512] = wbuf[i];
    end
    bus_stop();
  endtask

  task automatic rd_txn(input logic [15:0] a, input int n, input string req);
    bit ack;
    logic [7:0] d;
    bus_start();
    send({DEV, 1'b0}, ack);
    send(a[15:8], ack);
    send(a[7:0], ack);
    bus_start();
    send({DEV, 1'b1}, ack); chk(ack, "R9 read device ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv(i < n - 1, d);
      chk(d == model[(idx(a) + i) % 512], req, d, model[(idx(a) + i) % 512]);
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    logic [15:0] a;
    int n;
    void'($urandom(32'h1c2d));
    for (int i = 0; i < 512; i++) model[i] = 8'h00;
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    wbuf[0] = 8'h3C; wbuf[1] = 8'h81; wbuf[2] = 8'hE7;
    wr_txn(16'h0020, 3);
    chk(sda_oe == 1'b0, "R3 released after stop", sda_oe, 0);
    rd_txn(16'h0020, 3, "R7 sequential read");

    rd_txn(16'h0100, 2, "R1 cleared byte");

    wbuf[0] = 8'hA5;
    wr_txn(16'hFE40, 1);
    rd_txn(16'h0040, 1, "R5 upper bits ignored");

    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    wr_txn(16'h01FF, 2);
    rd_txn(16'h0000, 1, "R8 write wrap");
    rd_txn(16'h01FF, 2, "R8 read wrap");

    bus_start();
    send({7'h51, 1'b0}, ack); chk(!ack, "R4 mismatch nack", ack, 0);
    send(8'h00, ack);         chk(!ack, "R4 ignored byte nack", ack, 0);
    send(8'h20, ack);
    send(8'hFF, ack);
    bus_stop();
    rd_txn(16'h0020, 1, "R4 foreign write ignored");

    bus_start();
    send({DEV, 1'b0}, ack);
    send(8'h00, ack);
    send(8'h20, ack);
    bus_start();
    send({DEV, 1'b1}, ack);
    recv(1'b0, d);
    chk(d == 8'h3C, "R7 nack read", d, 8'h3C);
    recv(1'b0, d);
    chk(d == 8'hFF, "R7 quiet after nack", d, 8'hFF);
    bus_stop();

    bus_start();
    send({DEV, 1'b0}, ack);
    send(8'h00, ack);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    wbuf[0] = 8'h5A;
    wr_txn(16'h0030, 1);
    rd_txn(16'h0030, 1, "R2 start mid-byte");

    bus_start();
    send({DEV, 1'b1}, ack);
    recv(1'b0, d);
    chk(d == model[16'h31], "R9 current address read", d, model[16'h31]);
    bus_stop();

    for (int t = 0; t < 14; t++) begin
      a = 16'($urandom());
      n = 1 + int'($urandom_range(5));
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom());
      wr_txn(a, n);
      rd_txn(a, n, "R6 random write readback");
    end
    for (int t = 0; t < 6; t++) begin
      a = 16'($urandom());
      rd_txn(a, 3, "R9 random read");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule